// File: doc/BRIEF.md
# Host-to-PCI Request Decoder and Command Selector

This block sits on the processor side of a host-to-PCI bridge. Each local request carries an address, a direction, a byte count, a source flag (processor or DMA engine) and a request kind. For ordinary space accesses the block checks three programmable windows: memory window 0, memory window 1 and an I/O window. It then picks the PCI bus command for the window that claims the address. Configuration, interrupt-acknowledge and special-cycle requests are named by their kind and bypass the windows.

The result is one registered descriptor per accepted request. It holds the command, the unmodified address, the length, the source flag, the claiming window and a no-hit flag, and it is passed on with a valid/ready handshake. Memory read line and memory write-and-invalidate are picked only when the byte count equals a programmable cache line size. A line size of zero turns both off. The command set has no dual-address or locked form.

Top module: `pci_cmd_decode`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `dsc_valid` is 0.
- R2: An accepted request's address, length and source flag appear in the descriptor bit for bit, with no offset.
- R3: A window claims an address when `(addr & mask) == (base & mask)`. Window 0 has priority over window 1, which has priority over I/O. `dsc_win` encodes the claimant as 0 = memory 0, 1 = memory 1, 2 = I/O, 3 = none.
- R4: A kind-0 (space) access claimed by a memory window gives command 0x6 for a read and 0x7 for a write when the length is not equal to a nonzero line size.
- R5: A memory-window access whose length equals a nonzero line size gives 0xE for a read and 0xF for a write.
- R6: When the line size is 0, neither 0xE nor 0xF is produced, even for a length of 0.
- R7: An access claimed by the I/O window gives 0x2 for a read and 0x3 for a write, whatever the length.
- R8: Kind 1 (configuration) gives 0xA for a read and 0xB for a write. No window is decoded, and `dsc_win` is 3 with no-hit 0.
- R9: Kind 2 gives 0x0 (interrupt acknowledge) and kind 3 gives 0x1 (special cycle), whatever the direction. `dsc_win` is 3 with no-hit 0.
- R10: A kind-0 access that no window claims gives a descriptor with `dsc_nohit` = 1, command 0x0 and `dsc_win` = 3.
- R11: `req_ready` equals `!dsc_valid || dsc_ready`. Each accepted request yields exactly one descriptor on the next cycle, and that descriptor holds steady while it is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_addr | input | AW | Local address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LW | Transfer length in bytes |
| req_dma | input | 1 | Request comes from the DMA engine |
| req_kind | input | 2 | 0 space, 1 configuration, 2 interrupt acknowledge, 3 special cycle |
| cfg_m0_base | input | AW | Memory window 0 base |
| cfg_m0_mask | input | AW | Memory window 0 compare mask |
| cfg_m1_base | input | AW | Memory window 1 base |
| cfg_m1_mask | input | AW | Memory window 1 compare mask |
| cfg_io_base | input | AW | I/O window base |
| cfg_io_mask | input | AW | I/O window compare mask |
| cfg_line_bytes | input | LW | Cache line size in bytes, 0 disables line commands |
| dsc_valid | output | 1 | Descriptor present |
| dsc_ready | input | 1 | Descriptor consumed |
| dsc_cmd | output | 4 | PCI bus command |
| dsc_addr | output | AW | PCI address |
| dsc_len | output | LW | Transfer length |
| dsc_dma | output | 1 | Source flag |
| dsc_win | output | 2 | Claiming window |
| dsc_nohit | output | 1 | No window claimed the access |

## Verification
A wrong window priority or mask compare shows as a wrong `dsc_win` and command on the cycle after acceptance. This is exposed by overlapping-window setups in which two windows match the same address. A line-size compare that is off or not gated by zero shows as 0xE/0xF appearing or missing in that same cycle. A faulty handshake register shows as a dropped, duplicated or changed descriptor during a stall. The per-cycle reference model sees it on the first cycle where the valid flag or a field departs from its queue.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    KIND_SPACE = 2'd0,
    KIND_CFG   = 2'd1,
    KIND_IACK  = 2'd2,
    KIND_SPEC  = 2'd3
  } req_kind_e;

  localparam logic [3:0] CMD_IACK  = 4'h0;
  localparam logic [3:0] CMD_SPEC  = 4'h1;
  localparam logic [3:0] CMD_IORD  = 4'h2;
  localparam logic [3:0] CMD_IOWR  = 4'h3;
  localparam logic [3:0] CMD_MRD   = 4'h6;
  localparam logic [3:0] CMD_MWR   = 4'h7;
  localparam logic [3:0] CMD_CFGRD = 4'hA;
  localparam logic [3:0] CMD_CFGWR = 4'hB;
  localparam logic [3:0] CMD_MRL   = 4'hE;
  localparam logic [3:0] CMD_MWI   = 4'hF;

  localparam logic [1:0] WIN_M0   = 2'd0;
  localparam logic [1:0] WIN_M1   = 2'd1;
  localparam logic [1:0] WIN_IO   = 2'd2;
  localparam logic [1:0] WIN_NONE = 2'd3;

  localparam int NUM_WIN = 3;
endpackage

// File: rtl/pcb_window_match.sv
module pcb_window_match #(
  parameter int AW   = 32,
  parameter int NWIN = 3
) (
  input  logic [AW-1:0]           addr,
  input  logic [NWIN-1:0][AW-1:0] base,
  input  logic [NWIN-1:0][AW-1:0] mask,
  output logic [NWIN-1:0]         grant
);
  logic [NWIN-1:0] raw_hit;

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_win
      assign raw_hit[g] = ((addr & mask[g]) == (base[g] & mask[g]));
    end
  endgenerate

  // Lowest index wins: scan downward so the last write is the lowest hit.
  always_comb begin
    grant = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcb_cmd_select.sv
module pcb_cmd_select
  import pcb_pkg::*;
#(
  parameter int LW = 8
) (
  input  req_kind_e          kind,
  input  logic               write,
  input  logic [LW-1:0]      len,
  input  logic [LW-1:0]      line_bytes,
  input  logic [NUM_WIN-1:0] grant,
  output logic [3:0]         cmd,
  output logic [1:0]         win,
  output logic               nohit
);
  logic line_match;

  assign line_match = (line_bytes != '0) && (len == line_bytes);

  always_comb begin
    cmd   = CMD_IACK;
    win   = WIN_NONE;
    nohit = 1'b0;
    unique case (kind)
      KIND_CFG:  cmd = write ? CMD_CFGWR : CMD_CFGRD;
      KIND_IACK: cmd = CMD_IACK;
      KIND_SPEC: cmd = CMD_SPEC;
      default: begin
        if (grant[0] || grant[1]) begin
          win = grant[0] ? WIN_M0 : WIN_M1;
          if (write) cmd = line_match ? CMD_MWI : CMD_MWR;
          else       cmd = line_match ? CMD_MRL : CMD_MRD;
        end else if (grant[2]) begin
          win = WIN_IO;
          cmd = write ? CMD_IOWR : CMD_IORD;
        end else begin
          nohit = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/pcb_desc_reg.sv
module pcb_desc_reg #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_cmd,
  input  logic [AW-1:0] in_addr,
  input  logic [LW-1:0] in_len,
  input  logic          in_dma,
  input  logic [1:0]    in_win,
  input  logic          in_nohit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3:0]    out_cmd,
  output logic [AW-1:0] out_addr,
  output logic [LW-1:0] out_len,
  output logic          out_dma,
  output logic [1:0]    out_win,
  output logic          out_nohit
);
  logic take;
  logic valid_nxt;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    if (take)           valid_nxt = 1'b1;
    else if (out_ready) valid_nxt = 1'b0;
    else                valid_nxt = out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cmd   <= '0;
      out_addr  <= '0;
      out_len   <= '0;
      out_dma   <= 1'b0;
      out_win   <= '0;
      out_nohit <= 1'b0;
    end else if (take) begin
      out_cmd   <= in_cmd;
      out_addr  <= in_addr;
      out_len   <= in_len;
      out_dma   <= in_dma;
      out_win   <= in_win;
      out_nohit <= in_nohit;
    end
  end

  // R11: a stalled descriptor neither disappears nor changes.
  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cmd) && $stable(out_addr)
                                   && $stable(out_len) && $stable(out_win)));

  // R11: an accepted request is visible on the next cycle.
  p_accept_shows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode
  import pcb_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [LW-1:0] req_len,
  input  logic          req_dma,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] cfg_m0_base,
  input  logic [AW-1:0] cfg_m0_mask,
  input  logic [AW-1:0] cfg_m1_base,
  input  logic [AW-1:0] cfg_m1_mask,
  input  logic [AW-1:0] cfg_io_base,
  input  logic [AW-1:0] cfg_io_mask,
  input  logic [LW-1:0] cfg_line_bytes,
  output logic          dsc_valid,
  input  logic          dsc_ready,
  output logic [3:0]    dsc_cmd,
  output logic [AW-1:0] dsc_addr,
  output logic [LW-1:0] dsc_len,
  output logic          dsc_dma,
  output logic [1:0]    dsc_win,
  output logic          dsc_nohit
);
  logic [NUM_WIN-1:0][AW-1:0] win_base;
  logic [NUM_WIN-1:0][AW-1:0] win_mask;
  logic [NUM_WIN-1:0]         grant;
  logic [3:0]                 sel_cmd;
  logic [1:0]                 sel_win;
  logic                       sel_nohit;
  req_kind_e                  kind;

  assign win_base = {cfg_io_base, cfg_m1_base, cfg_m0_base};
  assign win_mask = {cfg_io_mask, cfg_m1_mask, cfg_m0_mask};
  assign kind     = req_kind_e'(req_kind);

  pcb_window_match #(.AW(AW), .NWIN(NUM_WIN)) u_match (
    .addr  (req_addr),
    .base  (win_base),
    .mask  (win_mask),
    .grant (grant)
  );

  pcb_cmd_select #(.LW(LW)) u_sel (
    .kind       (kind),
    .write      (req_write),
    .len        (req_len),
    .line_bytes (cfg_line_bytes),
    .grant      (grant),
    .cmd        (sel_cmd),
    .win        (sel_win),
    .nohit      (sel_nohit)
  );

  pcb_desc_reg #(.AW(AW), .LW(LW)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_cmd    (sel_cmd),
    .in_addr   (req_addr),
    .in_len    (req_len),
    .in_dma    (req_dma),
    .in_win    (sel_win),
    .in_nohit  (sel_nohit),
    .out_valid (dsc_valid),
    .out_ready (dsc_ready),
    .out_cmd   (dsc_cmd),
    .out_addr  (dsc_addr),
    .out_len   (dsc_len),
    .out_dma   (dsc_dma),
    .out_win   (dsc_win),
    .out_nohit (dsc_nohit)
  );

  // R2: address, length and source pass through untouched.
  p_addr_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (dsc_addr == $past(req_addr) && dsc_len == $past(req_len)
                                  && dsc_dma == $past(req_dma)));

  // R6: without an exact nonzero line match, no line command appears.
  p_no_line_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(cfg_line_bytes != '0 && req_len == cfg_line_bytes))
      |=> (dsc_cmd != CMD_MRL && dsc_cmd != CMD_MWI));

  // R10: a miss carries the fixed miss encoding.
  p_nohit_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && dsc_nohit) |-> (dsc_cmd == CMD_IACK && dsc_win == WIN_NONE));

  // R8: configuration requests never report a window.
  p_cfg_nowin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd1) |=> (dsc_win == WIN_NONE && !dsc_nohit));
endmodule

// File: tb/pci_cmd_decode_bench.sv
`timescale 1ns/1ps
module pci_cmd_decode_bench;
  localparam int AW = 32;
  localparam int LW = 8;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          req_write;
  logic [LW-1:0] req_len;
  logic          req_dma;
  logic [1:0]    req_kind;
  logic [AW-1:0] m0_base, m0_mask, m1_base, m1_mask, io_base, io_mask;
  logic [LW-1:0] line_bytes;
  logic          dsc_valid;
  logic          dsc_ready;
  logic [3:0]    dsc_cmd;
  logic [AW-1:0] dsc_addr;
  logic [LW-1:0] dsc_len;
  logic          dsc_dma;
  logic [1:0]    dsc_win;
  logic          dsc_nohit;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    logic [3:0]    cmd;
    logic [1:0]    win;
    logic          nohit;
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
    logic          dma;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  pci_cmd_decode #(.AW(AW), .LW(LW)) u_pci_cmd_decode (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_len(req_len), .req_dma(req_dma), .req_kind(req_kind),
    .cfg_m0_base(m0_base), .cfg_m0_mask(m0_mask),
    .cfg_m1_base(m1_base), .cfg_m1_mask(m1_mask),
    .cfg_io_base(io_base), .cfg_io_mask(io_mask),
    .cfg_line_bytes(line_bytes),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_cmd(dsc_cmd),
    .dsc_addr(dsc_addr), .dsc_len(dsc_len), .dsc_dma(dsc_dma),
    .dsc_win(dsc_win), .dsc_nohit(dsc_nohit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference for a single request.
  function automatic exp_t predict();
    exp_t e;
    bool_hits: begin end
    e.addr  = req_addr;
    e.len   = req_len;
    e.dma   = req_dma;
    e.nohit = 1'b0;
    e.win   = 2'd3;
    if (req_kind == 2'd1) begin
      e.cmd = req_write ? 4'hB : 4'hA;  e.tag = "R8";
    end else if (req_kind == 2'd2) begin
      e.cmd = 4'h0;  e.tag = "R9";
    end else if (req_kind == 2'd3) begin
      e.cmd = 4'h1;  e.tag = "R9";
    end else begin
      bit h0, h1, hio;
      h0  = (req_addr & m0_mask) == (m0_base & m0_mask);
      h1  = (req_addr & m1_mask) == (m1_base & m1_mask);
      hio = (req_addr & io_mask) == (io_base & io_mask);
      if (h0 || h1) begin
        e.win = h0 ? 2'd0 : 2'd1;
        if (line_bytes != 0 && req_len == line_bytes) begin
          e.cmd = req_write ? 4'hF : 4'hE;  e.tag = "R5";
        end else begin
          e.cmd = req_write ? 4'h7 : 4'h6;
          e.tag = (line_bytes == 0) ? "R6" : "R4";
        end
      end else if (hio) begin
        e.win = 2'd2;  e.cmd = req_write ? 4'h3 : 4'h2;  e.tag = "R7";
      end else begin
        e.nohit = 1'b1;  e.cmd = 4'h0;  e.tag = "R10";
      end
    end
    return e;
  endfunction

  // Reference state update at each rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
    end else begin
      bit rdy;
      rdy = (exp_q.size() == 0) || dsc_ready;
      if (dsc_ready && exp_q.size() > 0) void'(exp_q.pop_front());
      if (req_valid && rdy) exp_q.push_back(predict());
    end
  end

  task automatic compare();
    bit mv;
    mv = exp_q.size() > 0;
    check(dsc_valid == mv, "R11", "dsc_valid", dsc_valid, mv);
    check(req_ready == (!mv || dsc_ready), "R11", "req_ready", req_ready, !mv || dsc_ready);
    if (mv && dsc_valid) begin
      exp_t e;
      e = exp_q[0];
      check(dsc_cmd == e.cmd, e.tag, "dsc_cmd", dsc_cmd, e.cmd);
      check(dsc_win == e.win, "R3", "dsc_win", dsc_win, e.win);
      check(dsc_nohit == e.nohit, "R10", "dsc_nohit", dsc_nohit, e.nohit);
      check(dsc_addr == e.addr, "R2", "dsc_addr", dsc_addr, e.addr);
      check(dsc_len == e.len, "R2", "dsc_len", dsc_len, e.len);
      check(dsc_dma == e.dma, "R2", "dsc_dma", dsc_dma, e.dma);
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    logic [15:0] hi;
    case ($urandom_range(0, 7))
      0: hi = 16'h1000;
      1: hi = 16'h10AB;
      2: hi = 16'h8000;
      3: hi = 16'hA123;
      4: hi = 16'h0001;
      5: hi = 16'h5000;
      6: hi = 16'hF000;
      default: hi = 16'h8001;
    endcase
    return {hi, 16'($urandom)};
  endfunction

  task automatic set_windows(input bit overlap, input logic [LW-1:0] lb);
    line_bytes = lb;
    m0_base = 32'h1000_0000;  m0_mask = 32'hF000_0000;
    if (!overlap) begin
      m1_base = 32'h8000_0000;  m1_mask = 32'hC000_0000;
      io_base = 32'h0001_0000;  io_mask = 32'hFFFF_0000;
    end else begin
      // window 1 lies inside window 0, I/O lies inside window 1 (R3 priority)
      m1_base = 32'h1000_0000;  m1_mask = 32'hFF00_0000;
      io_base = 32'h1000_0000;  io_mask = 32'hFFFF_0000;
    end
  endtask

  task automatic run_phase(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      if (!(req_valid && !req_ready)) begin
        req_valid = ($urandom_range(0, 3) != 0);
        req_addr  = pick_addr();
        req_write = 1'($urandom);
        req_kind  = ($urandom_range(0, 4) < 3) ? 2'd0 : 2'($urandom);
        req_dma   = 1'($urandom);
        case ($urandom_range(0, 3))
          0: req_len = line_bytes;
          1: req_len = '0;
          default: req_len = 8'($urandom);
        endcase
      end
      dsc_ready = ($urandom_range(0, 9) < 7);
    end
  endtask

  initial begin
    rst_n = 1'b0;  req_valid = 1'b0;  req_addr = '0;  req_write = 1'b0;
    req_len = '0;  req_dma = 1'b0;  req_kind = 2'd0;  dsc_ready = 1'b0;
    set_windows(1'b0, 8'd32);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(dsc_valid == 1'b0, "R1", "dsc_valid in reset", dsc_valid, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(dsc_valid == 1'b0, "R1", "dsc_valid after reset", dsc_valid, 0);
    run_phase(3000);
    set_windows(1'b1, 8'd64);
    run_phase(3000);
    set_windows(1'b0, 8'd0);  // R6: line commands disabled
    run_phase(3000);
    set_windows(1'b1, 8'd0);
    run_phase(2000);
    req_valid = 1'b0;  dsc_ready = 1'b1;
    run_phase(0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule